// File: doc/BRIEF.md
# Register Write Command Packer

This block turns a stream of register-write requests into the dword command buffer that a display sequencing engine later executes. Each request gives a 20-bit register offset, a 32-bit value and a flag. The flag picks either a plain single write or an auto-increment write, in which one instruction carries many values for one register. A run of auto-increment requests to the same register is folded into one instruction. The block appends each value to that instruction and rewrites the instruction's size word in place.

The buffer is an internal dual-port RAM. The packer owns its write port. The consumer reads dwords through a registered read port and uses the `tail` output to know how many dwords are valid. Every instruction starts on an even dword index. When an instruction ends on an odd index, the dword after it is written as zero. A request that would not fit in the buffer is discarded and raises a sticky overflow flag. The `clear` input empties the buffer logically.

Each accepted request needs two to four RAM writes. The block issues these one per cycle and holds `req_ready` low until they are done.

Top module: `cmd_packer`

## Requirements
- R1: After reset, `tail` is 0, `overflow` is 0 and `req_ready` is 1.
- R2: A single write placed at aligned index s stores the data at s and the dword {8'h01, 4'hF, offset} at s+1 (opcode in bits 31:24, byte enables in bits 23:20, offset in bits 19:0). `tail` becomes s+2.
- R3: An auto-increment request that opens a new instruction at aligned index s stores the following:
  - the size word 1 at s;
  - {8'h09, 4'h0, offset} at s+1;
  - the data at s+2;
  - zero at s+3.
  `tail` becomes s+3.
- R4: An auto-increment request whose offset equals the offset of the open auto-increment instruction appends its data at `tail`, writes the incremented count into that instruction's size word and advances `tail` by 1. If the new `tail` is odd, the dword at the new `tail` is written as zero.
- R5: Every new instruction, single or auto-increment, starts at `tail` rounded up to the next even index.
- R6: An auto-increment request never merges into a single write, even one to the same offset, nor into an instruction for a different offset. It opens a new instruction instead.
- R7: A request whose dwords (including alignment) would extend past DEPTH is dropped. The buffer contents and `tail` stay unchanged. `overflow` is set and stays set until `clear` or reset.
- R8: A `clear` pulse returns `tail` to 0 and `overflow` to 0 and closes the open instruction. The next auto-increment request therefore starts a new instruction at 0, even if it names the previous offset.
- R9: `tail` updates in the cycle after acceptance. `req_ready` is low from that cycle until all of the request's dwords are written. `rd_data` shows the dword at `rd_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous release: empties the buffer and clears overflow |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_indexed | input | 1 | 1 = auto-increment write, 0 = single write |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Register value |
| tail | output | $clog2(DEPTH+1) | Number of valid dwords (write pointer) |
| overflow | output | 1 | Sticky flag: a request was dropped |
| rd_addr | input | $clog2(DEPTH) | Consumer read address |
| rd_data | output | 32 | Dword at rd_addr, one cycle later |

## Verification
The bench covers the following corner cases, each with the fault it would expose:
- An auto-increment write to the same register right after a single write. A design that merges on the offset alone would bump the single write's data word as if it were a size word.
- Runs that leave `tail` odd and then start another instruction. Missing alignment would place the instruction on an odd index, and missing padding would leave stale data in the gap.
- Filling the buffer to its exact end and then past it. An off-by-one fit test would either drop a request that fits or write past the last dword and move `tail` beyond DEPTH.
- A clear followed by the same offset. Stale open-instruction state would append to a size word that no longer exists.

// File: rtl/cmd_packer.sv
module cmd_packer #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int TW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_indexed,
  input  logic [19:0]   req_offset,
  input  logic [31:0]   req_data,
  output logic [TW-1:0] tail,
  output logic          overflow,
  input  logic [IW-1:0] rd_addr,
  output logic [31:0]   rd_data
);

  localparam logic [7:0] OP_SINGLE = 8'h01;
  localparam logic [7:0] OP_INDEX  = 8'h09;
  localparam int NSLOT = 4;

  logic [31:0]   mem [DEPTH];
  logic [TW-1:0] tail_q, start_q;
  logic          open_q, ovf_q;
  logic [19:0]   open_off_q;
  logic [31:0]   size_q;

  logic [NSLOT-1:0] sv, sv_n;
  logic [IW-1:0]    sa   [NSLOT];
  logic [IW-1:0]    sa_n [NSLOT];
  logic [31:0]      sd   [NSLOT];
  logic [31:0]      sd_n [NSLOT];

  logic          acc, merge, fits;
  logic [TW-1:0] algn, base;
  logic [TW:0]   endp;
  logic [2:0]    need;
  logic [IW-1:0] bi;

  assign req_ready = ~sv[0] & ~clear;
  assign acc       = req_valid & req_ready;
  assign merge     = req_indexed & open_q & (req_offset == open_off_q);
  assign algn      = tail_q + TW'(tail_q[0]);
  assign base      = merge ? tail_q : algn;
  assign need      = merge ? 3'd1 : (req_indexed ? 3'd3 : 3'd2);
  assign endp      = {1'b0, base} + (TW+1)'(need);
  assign fits      = endp <= (TW+1)'(DEPTH);
  assign bi        = base[IW-1:0];
  assign tail      = tail_q;
  assign overflow  = ovf_q;

  always_comb begin
    sv_n = '0;
    for (int k = 0; k < NSLOT; k++) begin
      sa_n[k] = '0;
      sd_n[k] = '0;
    end
    if (merge) begin
      sv_n    = {1'b0, ~tail_q[0], 2'b11};
      sa_n[0] = bi;
      sd_n[0] = req_data;
      sa_n[1] = start_q[IW-1:0];
      sd_n[1] = size_q + 32'd1;
      sa_n[2] = bi + IW'(1);
    end else if (req_indexed) begin
      sv_n    = 4'b1111;
      sa_n[0] = bi;
      sd_n[0] = 32'd1;
      sa_n[1] = bi + IW'(1);
      sd_n[1] = {OP_INDEX, 4'h0, req_offset};
      sa_n[2] = bi + IW'(2);
      sd_n[2] = req_data;
      sa_n[3] = bi + IW'(3);
    end else begin
      sv_n    = 4'b0011;
      sa_n[0] = bi;
      sd_n[0] = req_data;
      sa_n[1] = bi + IW'(1);
      sd_n[1] = {OP_SINGLE, 4'hF, req_offset};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q     <= '0;
      start_q    <= '0;
      open_q     <= 1'b0;
      open_off_q <= '0;
      size_q     <= '0;
      ovf_q      <= 1'b0;
    end else if (clear) begin
      tail_q  <= '0;
      start_q <= '0;
      open_q  <= 1'b0;
      size_q  <= '0;
      ovf_q   <= 1'b0;
    end else if (acc) begin
      if (!fits) begin
        ovf_q <= 1'b1;
      end else if (merge) begin
        tail_q <= tail_q + TW'(1);
        size_q <= size_q + 32'd1;
      end else begin
        start_q    <= base;
        tail_q     <= base + TW'(need);
        open_q     <= req_indexed;
        open_off_q <= req_offset;
        size_q     <= 32'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0;
      for (int k = 0; k < NSLOT; k++) begin
        sa[k] <= '0;
        sd[k] <= '0;
      end
    end else if (clear) begin
      sv <= '0;
    end else if (acc && fits) begin
      sv <= sv_n;
      for (int k = 0; k < NSLOT; k++) begin
        sa[k] <= sa_n[k];
        sd[k] <= sd_n[k];
      end
    end else if (sv[0]) begin
      sv <= {1'b0, sv[NSLOT-1:1]};
      for (int k = 0; k < NSLOT - 1; k++) begin
        sa[k] <= sa[k+1];
        sd[k] <= sd[k+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sv[0]) mem[sa[0]] <= sd[0];
    rd_data <= mem[rd_addr];
  end

  AST_TAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) tail_q <= TW'(DEPTH)); // R7
  AST_START_EVEN: assert property (@(posedge clk) disable iff (!rst_n) !start_q[0]); // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ovf_q && !clear |=> ovf_q); // R7
  AST_MERGE_STEP: assert property (@(posedge clk) disable iff (!rst_n) acc && merge && fits |=> tail_q == $past(tail_q) + TW'(1)); // R4
  AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n) acc && !fits |=> tail_q == $past(tail_q) && ovf_q); // R7
  AST_BUSY_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n) acc && fits |=> !req_ready); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clear |=> tail_q == '0 && !ovf_q); // R8

endmodule

// File: tb/cmd_packer_tb.sv
module cmd_packer_tb;
  localparam int DEPTH = 64;
  localparam int IW = $clog2(DEPTH);
  localparam int TW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, clear = 1'b0;
  logic req_valid = 1'b0, req_indexed = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic [IW-1:0] rd_addr = '0;
  logic req_ready, overflow;
  logic [TW-1:0] tail;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  logic [31:0] mem_m [DEPTH];
  int tail_m = 0, start_m = 0, size_m = 0;
  bit open_m = 0, ovf_m = 0;
  logic [19:0] off_m = '0;

  always #5 clk = ~clk;

  cmd_packer #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_offset(req_offset), .req_data(req_data),
    .tail(tail), .overflow(overflow),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model(input bit idx, input logic [19:0] off, input logic [31:0] d);
    bit mg;
    int b, need;
    mg = idx && open_m && off == off_m;
    b = mg ? tail_m : tail_m + (tail_m % 2);
    need = mg ? 1 : (idx ? 3 : 2);
    if (b + need > DEPTH) begin
      ovf_m = 1;
      return;
    end
    if (mg) begin
      mem_m[b] = d;
      size_m++;
      mem_m[start_m] = size_m;
      tail_m = b + 1;
      if (tail_m % 2 == 1) mem_m[tail_m] = '0;
    end else if (idx) begin
      mem_m[b] = 32'd1;
      mem_m[b+1] = {8'h09, 4'h0, off};
      mem_m[b+2] = d;
      mem_m[b+3] = '0;
      tail_m = b + 3; start_m = b; size_m = 1; open_m = 1; off_m = off;
    end else begin
      mem_m[b] = d;
      mem_m[b+1] = {8'h01, 4'hF, off};
      tail_m = b + 2; start_m = b; open_m = 0;
    end
  endtask

  task automatic send(input bit idx, input logic [19:0] off, input logic [31:0] d, input string req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_indexed = idx; req_offset = off; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    model(idx, off, d);
    chk(tail == TW'(tail_m), {req, " tail"}, 32'(tail), 32'(tail_m));
    chk(overflow == ovf_m, {req, " overflow"}, 32'(overflow), 32'(ovf_m));
  endtask

  task automatic dump(input string req);
    int lim;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    lim = tail_m + (tail_m % 2);
    if (lim > DEPTH) lim = DEPTH;
    for (int i = 0; i < lim; i++) begin
      rd_addr = IW'(i);
      @(negedge clk);
      chk(rd_data === mem_m[i], $sformatf("%s word %0d", req, i), rd_data, mem_m[i]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    tail_m = 0; start_m = 0; size_m = 0; open_m = 0; ovf_m = 0;
    chk(tail == '0, "R8 tail after clear", 32'(tail), 0);
    chk(overflow == 1'b0, "R8 overflow after clear", 32'(overflow), 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tail == '0, "R1 tail", 32'(tail), 0);
    chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);

    // R2 single, R6 no merge into single, R4 merges, R5 alignment
    send(0, 20'h4A000, 32'hDEAD0001, "R2");
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 0);
    send(1, 20'h4A000, 32'h11111111, "R6");
    send(1, 20'h4A000, 32'h22222222, "R4");
    send(1, 20'h4A000, 32'h33333333, "R4");
    send(1, 20'h4A004, 32'h44444444, "R5");
    send(0, 20'h00123, 32'h55555555, "R5");
    send(1, 20'h4A004, 32'h66666666, "R6");
    dump("R2 R3 R4 R5 R6 directed");

    // R8 clear then same offset
    do_clear();
    send(1, 20'h4A004, 32'h77777777, "R8");
    chk(tail == TW'(3), "R3 new at zero", 32'(tail), 3);
    dump("R3 R8 after clear");

    // random mix
    for (int batch = 0; batch < 6; batch++) begin
      do_clear();
      for (int n = 0; n < 18; n++) begin
        bit idx;
        logic [19:0] off;
        idx = ($urandom % 10) < 7;
        off = 20'h60000 + 20'($urandom % 3) * 20'h4;
        send(idx, off, $urandom, "R4 random");
      end
      dump("R2 R3 R4 random");
    end

    // R7 fill to the end
    do_clear();
    for (int n = 0; n < 16; n++) send(1, 20'(n * 4), 32'(n), "R7 fill");
    chk(tail == TW'(63), "R7 tail full", 32'(tail), 63);
    send(1, 20'h00100, 32'hBAD0BAD0, "R7 drop new");
    chk(overflow == 1'b1, "R7 overflow set", 32'(overflow), 1);
    send(1, 20'(15 * 4), 32'hF00DF00D, "R7 last merge fits");
    chk(tail == TW'(64), "R7 tail at depth", 32'(tail), 64);
    send(1, 20'(15 * 4), 32'hBAD1BAD1, "R7 drop merge");
    send(0, 20'h00200, 32'hBAD2BAD2, "R7 drop single");
    repeat (3) @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow sticky", 32'(overflow), 1);
    dump("R7 contents kept");
    do_clear();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule